// File: doc/BRIEF.md
# Chorus Delay Modulation Oscillator

This block produces a slowly swinging delay length for a chorus effect. A phase accumulator steps forward once per audio sample tick by a programmable frequency word. Its upper bits select an entry from a built-in table holding one cycle of a raised sine. That entry is multiplied by an amplitude control to give an unsigned count of delay ticks. One tick is one sample period at 44.1 kHz. With the default 24-bit phase, frequency words of about 38 to 1902 cover 0.1 Hz to 5 Hz. Amplitudes up to 4410 cover delays of up to 100 ms.

A small sequencer handles each sample tick. In `ST_WAIT` it idles until a tick strobe arrives, and that strobe advances the phase (transition WAIT to FETCH). In `ST_FETCH` it registers the table entry addressed by the new phase (transition FETCH to APPLY). In `ST_APPLY` it scales the entry and loads the delay output (transition APPLY to WAIT). Between these updates the output holds steady, so the delay line that reads it sees one value per sample.

Top module: `lfo_delay_gen`

## Requirements
- R1: After reset the phase is zero and `delay_o` is 0.
- R2: A tick strobe that is sampled in `ST_WAIT` adds `freq_i` (zero-extended) to the PHASE_W-bit phase exactly once.
- R3: Table entry i, for i from 0 to 2^ADDR_W-1, equals round(32767.5 × (sin(2πi/2^ADDR_W) + 1)) within one LSB. It lies in 0..65535 and is addressed by the top ADDR_W bits of the phase.
- R4: The strobe sampled at rising edge k moves the sequencer WAIT→FETCH. The next edge moves it FETCH→APPLY. At edge k+2 the sequencer returns APPLY→WAIT and `delay_o` takes its new value.
- R5: The new `delay_o` equals (entry × `scale_i`) >> 16. It therefore never exceeds `scale_i`, and it is 0 whenever `scale_i` is 0.
- R6: `delay_o` holds its value between updates, even while `scale_i` and `freq_i` change.
- R7: A strobe that is sampled while the sequencer is in `ST_FETCH` or `ST_APPLY` is ignored: the phase does not advance.
- R8: The phase wraps modulo 2^PHASE_W, so the table index runs continuously through entry 2^ADDR_W-1 back to entry 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe per audio sample |
| freq_i | input | FREQ_W | Phase increment per sample tick |
| scale_i | input | SCALE_W | Peak delay in sample ticks |
| delay_o | output | SCALE_W | Modulated delay in sample ticks |

## Verification
With a frequency word of exactly one table step per tick, the bench walks every table entry in turn and past the wrap. A table that is mirrored or shifted by one quadrant, or an index that skips or stalls at the wrap, shows up against the arithmetic sine at that entry. Amplitudes of 0, 1, 4410 and the field maximum are run with an odd stride. A scaler that shifts by the wrong amount, or that truncates the product width, then gives values above the amplitude or the wrong peak. A strobe held for two cycles must advance the phase only once; a design that accepted both cycles would land two entries further on. Changing the controls between ticks must leave the output untouched; a design that scaled combinationally would follow the change at once.

// File: rtl/lfo_pkg.sv
package lfo_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_FETCH = 2'd1,
        ST_APPLY = 2'd2
    } lfo_state_e;

    localparam int unsigned ENTRY_W = 16;

    // Raised sine sample: round(32767.5*(sin(2*pi*idx/2^addr_w)+1)),
    // evaluated with a Q30 Taylor series so no real arithmetic is needed.
    function automatic logic [ENTRY_W-1:0] sine_entry(input int unsigned idx,
                                                      input int unsigned addr_w);
        longint half;
        longint q;
        longint x;
        longint term;
        longint sum;
        longint one;
        longint pi_q30;
        longint lvl;
        bit     neg;
        one    = 64'sd1 <<< 30;
        pi_q30 = 64'sd3373259426;
        half   = 64'sd1 <<< (addr_w - 1);
        q      = longint'(idx) % (half * 2);
        neg    = (q >= half);
        if (neg) q = q - half;
        if (q > half / 2) q = half - q;
        x    = (q * pi_q30) / half;
        term = x;
        sum  = x;
        for (int n = 1; n <= 6; n++) begin
            term = (term * x) >>> 30;
            term = (term * x) >>> 30;
            term = -term / longint'((2 * n) * (2 * n + 1));
            sum  = sum + term;
        end
        if (sum > one) sum = one;
        if (sum < 0)   sum = 0;
        lvl = neg ? (one - sum) : (one + sum);
        return ENTRY_W'((lvl * 65535 + one) / (one * 2));
    endfunction

endpackage

// File: rtl/lfo_sine_rom.sv
module lfo_sine_rom #(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]          addr,
    output logic [lfo_pkg::ENTRY_W-1:0] entry
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [lfo_pkg::ENTRY_W-1:0] table_w [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        localparam logic [lfo_pkg::ENTRY_W-1:0] VAL =
            lfo_pkg::sine_entry(k, ADDR_W);
        assign table_w[k] = VAL;
    end

    assign entry = table_w[addr];
endmodule

// File: rtl/lfo_phase_acc.sv
module lfo_phase_acc #(
    parameter int unsigned PHASE_W = 24,
    parameter int unsigned FREQ_W  = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    input  logic [FREQ_W-1:0]  freq,
    output logic [PHASE_W-1:0] phase
);
    localparam int unsigned PAD_W = PHASE_W - FREQ_W;

    logic [PHASE_W-1:0] step_w;
    assign step_w = {{PAD_W{1'b0}}, freq};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (adv) begin
            phase <= phase + step_w;
        end
    end
endmodule

// File: rtl/lfo_scaler.sv
module lfo_scaler #(
    parameter int unsigned SCALE_W = 13
) (
    input  logic [lfo_pkg::ENTRY_W-1:0] entry,
    input  logic [SCALE_W-1:0]          scale,
    output logic [SCALE_W-1:0]          value
);
    localparam int unsigned PROD_W = lfo_pkg::ENTRY_W + SCALE_W;

    logic [PROD_W-1:0] prod_w;
    assign prod_w = PROD_W'(entry) * PROD_W'(scale);
    assign value  = prod_w[PROD_W-1 -: SCALE_W];
endmodule

// File: rtl/lfo_delay_gen.sv
module lfo_delay_gen #(
    parameter int unsigned PHASE_W = 24,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned FREQ_W  = 20,
    parameter int unsigned SCALE_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic [FREQ_W-1:0]  freq_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic [SCALE_W-1:0] delay_o
);
    import lfo_pkg::*;

    lfo_state_e           state_q;
    lfo_state_e           state_d;
    logic                 adv_w;
    logic [PHASE_W-1:0]   phase_q;
    logic [ENTRY_W-1:0]   rom_w;
    logic [ENTRY_W-1:0]   entry_q;
    logic [SCALE_W-1:0]   scaled_w;

    assign adv_w = tick_i && (state_q == ST_WAIT);

    lfo_phase_acc #(.PHASE_W(PHASE_W), .FREQ_W(FREQ_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv_w),
        .freq  (freq_i),
        .phase (phase_q)
    );

    lfo_sine_rom #(.ADDR_W(ADDR_W)) u_rom (
        .addr  (phase_q[PHASE_W-1 -: ADDR_W]),
        .entry (rom_w)
    );

    lfo_scaler #(.SCALE_W(SCALE_W)) u_scale (
        .entry (entry_q),
        .scale (scale_i),
        .value (scaled_w)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:  if (tick_i) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_APPLY;
            ST_APPLY: state_d = ST_WAIT;
            default:  state_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q <= '0;
            delay_o <= '0;
        end else begin
            unique case (state_q)
                ST_FETCH: entry_q <= rom_w;
                ST_APPLY: delay_o <= scaled_w;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/lfo_delay_gen_chk.sv
module lfo_delay_gen_chk #(
    parameter int unsigned PHASE_W = 24,
    parameter int unsigned FREQ_W  = 20,
    parameter int unsigned SCALE_W = 13
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick_i,
    input logic [FREQ_W-1:0]   freq_i,
    input logic [SCALE_W-1:0]  scale_i,
    input logic [SCALE_W-1:0]  delay_o,
    input logic [PHASE_W-1:0]  phase_q,
    input lfo_pkg::lfo_state_e state_q
);
    import lfo_pkg::*;

    assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && state_q == ST_WAIT) |=>
            phase_q == PHASE_W'($past(phase_q) + PHASE_W'($past(freq_i))));

    assert_seq_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && state_q == ST_WAIT) |=> state_q == ST_FETCH);

    assert_seq_apply_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |=> state_q == ST_APPLY);

    assert_seq_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_APPLY) |=> state_q == ST_WAIT);

    assert_bounded_by_scale_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_APPLY) |=> delay_o <= $past(scale_i));

    assert_zero_scale_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_APPLY && scale_i == '0) |=> delay_o == '0);

    assert_output_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_APPLY) |=> $stable(delay_o));

    assert_busy_strobe_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_WAIT) |=> $stable(phase_q));
endmodule

bind lfo_delay_gen lfo_delay_gen_chk #(
    .PHASE_W (PHASE_W),
    .FREQ_W  (FREQ_W),
    .SCALE_W (SCALE_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .freq_i  (freq_i),
    .scale_i (scale_i),
    .delay_o (delay_o),
    .phase_q (phase_q),
    .state_q (state_q)
);

// File: tb/lfo_delay_gen_bench.sv
`timescale 1ns/1ps
module lfo_delay_gen_bench;
    localparam int unsigned PHASE_W = 24;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned FREQ_W  = 20;
    localparam int unsigned SCALE_W = 13;
    localparam real         TWO_PI  = 6.283185307179586;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               tick_i = 1'b0;
    logic [FREQ_W-1:0]  freq_i = '0;
    logic [SCALE_W-1:0] scale_i = '0;
    logic [SCALE_W-1:0] delay_o;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    longint      model_phase = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    lfo_delay_gen #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .FREQ_W(FREQ_W),
                    .SCALE_W(SCALE_W)) u_lfo_delay_gen (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .freq_i(freq_i), .scale_i(scale_i), .delay_o(delay_o)
    );

    function automatic longint ref_entry(input longint idx);
        real s;
        s = $sin(TWO_PI * real'(idx) / real'(1 << ADDR_W));
        return longint'($rtoi(32767.5 * (s + 1.0) + 0.5));
    endfunction

    function automatic longint ref_out(input longint ph, input longint sc);
        return (ref_entry(ph >> (PHASE_W - ADDR_W)) * sc) >> 16;
    endfunction

    task automatic compare(input string req, input longint act,
                           input longint exp, input longint tol);
        longint d;
        n_cmp++;
        d = act - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // strobe for hold_cycles edges, then wait until the update has landed
    task automatic do_tick(input int hold_cycles);
        @(negedge clk);
        tick_i = 1'b1;
        for (int i = 0; i < hold_cycles; i++) @(negedge clk);
        tick_i = 1'b0;
        while (u_lfo_delay_gen.state_q != lfo_pkg::ST_WAIT) @(negedge clk);
        model_phase = (model_phase + longint'(freq_i)) % (64'sd1 << PHASE_W);
    endtask

    task automatic tick_check(input string req);
        do_tick(1);
        compare(req, longint'(delay_o), ref_out(model_phase, longint'(scale_i)), 1);
        if (longint'(delay_o) > longint'(scale_i))
            compare("R5 bound", longint'(delay_o), longint'(scale_i), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        longint held;
        repeat (4) @(negedge clk);
        compare("R1 reset output", longint'(delay_o), 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 idle after reset", longint'(delay_o), 0, 0);

        // first tick with phase 0 + 0 -> entry 0 = 32768
        scale_i = 13'd4410;
        freq_i  = '0;
        tick_check("R1 zero phase");

        // one table step per tick through every entry and past the wrap
        freq_i = 20'h10000;
        for (int i = 0; i < 260; i++) tick_check("R3 R8 table sweep");

        // exact timing: output changes at the third edge from strobe sample
        freq_i = 20'h4000;
        @(negedge clk);
        tick_i = 1'b1;
        held = longint'(delay_o);
        @(negedge clk);
        tick_i = 1'b0;
        model_phase = (model_phase + 20'h4000) % (64'sd1 << PHASE_W);
        @(negedge clk);
        compare("R4 not yet updated", longint'(delay_o), held, 0);
        @(negedge clk);
        compare("R4 updated", longint'(delay_o), ref_out(model_phase, 4410), 1);

        // amplitude corners with an odd stride
        freq_i = 20'h0D3A7;
        scale_i = 13'd0;
        for (int i = 0; i < 64; i++) tick_check("R5 zero scale");
        scale_i = 13'd1;
        for (int i = 0; i < 64; i++) tick_check("R5 unit scale");
        scale_i = 13'd8191;
        for (int i = 0; i < 64; i++) tick_check("R5 max field scale");
        scale_i = 13'd4410;
        for (int i = 0; i < 64; i++) tick_check("R5 full depth");

        // slow and fast ends of the audio range
        freq_i = 20'd38;
        for (int i = 0; i < 16; i++) tick_check("R2 slow word");
        freq_i = 20'd1902;
        for (int i = 0; i < 16; i++) tick_check("R2 fast word");

        // controls change between ticks: output must not move
        freq_i = 20'h10000;
        tick_check("R6 before hold");
        held = longint'(delay_o);
        scale_i = 13'd77;
        freq_i  = 20'h23456;
        repeat (12) @(negedge clk);
        compare("R6 hold", longint'(delay_o), held, 0);
        scale_i = 13'd4410;
        freq_i  = 20'h10000;

        // strobe held two cycles advances once
        for (int i = 0; i < 8; i++) begin
            do_tick(2);
            compare("R7 busy strobe", longint'(delay_o),
                    ref_out(model_phase, 4410), 1);
        end
        tick_check("R7 follow-up");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule